// File: doc/BRIEF.md
# Pipelined Matrix-Vector Multiply Engine

This block multiplies an N x N coefficient matrix by an N-element sample vector (N = 8 by default). Samples stream in on a 12-bit port under a clock enable and fill a tap register that always holds the N most recent enabled samples. Coefficients are written one at a time through a row/column addressed write port before processing starts.

A start strobe copies the tap register into a hold register. The engine then steps through the coefficient rows in increasing order, one row per clock. Each row is multiplied against the held vector at full precision, summed through a registered adder tree, and passed through a round/select/limit stage. That stage shifts the sum right, rounds half-up and saturates it to a signed 16-bit result. Results leave one per clock behind a valid flag.

Because the vector is captured at start, the next vector can be streamed in while the current one is processed. A start issued on the last row cycle chains the next vector with no gap.

Top module: `mvm_engine`

## Requirements
- R1: While rst_ni is low, and after it rises until the first result, res_o is 0 and res_vld_o is 0.
- R2: Each rising edge with smp_en_i high shifts smp_i into the tap register, which holds the N most recent enabled samples, the oldest at column 0. An edge with smp_en_i low leaves the taps unchanged.
- R3: An edge with coef_we_i high stores coef_i (signed) as the coefficient at row coef_row_i, column coef_col_i. It stays until overwritten.
- R4: Result row r equals the round/select/limit of the exact signed sum over columns c of coef[r][c] x vec[c]. Sample and coefficient are 12-bit signed, and the sum is kept at 27 bits.
- R5: The first result appears on res_o after the (log2(N)+2)-th rising edge following the edge that accepts start_i, which is 5 edges for N = 8. Rows follow in increasing order, one per clock.
- R6: Each accepted start gives exactly N consecutive cycles of res_vld_o high. res_vld_o is low at all other times.
- R7: start_i is ignored while a run is busy on any row other than the last.
- R8: start_i sampled on the cycle of the last row is accepted. The next vector's N results then follow directly, with no idle cycle between runs.
- R9: The vector is captured at the accepting edge. Samples shifted in during a run do not change that run's results.
- R10: The result is the sum shifted right arithmetically by shift_i (0 to 26, held steady during a run). When shift_i > 0, 2^(shift_i-1) is added before the shift (round half-up). The value is then clamped to [-32768, 32767].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_en_i | input | 1 | Sample clock enable |
| smp_i | input | 12 | Signed sample |
| coef_we_i | input | 1 | Coefficient write enable |
| coef_row_i | input | 3 | Coefficient row (matrix row) |
| coef_col_i | input | 3 | Coefficient column (vector index) |
| coef_i | input | 12 | Signed coefficient |
| start_i | input | 1 | Start strobe for one matrix-vector run |
| shift_i | input | 5 | Right shift selecting the output window |
| res_o | output | 16 | Signed rounded and limited row result |
| res_vld_o | output | 1 | Result valid |

## Verification
The bench builds the engine with its defaults: N = 8, 12-bit samples and coefficients, and 16-bit results. With these values the three-level adder tree fixes the latency at five edges, and full-scale operands (-2048 x -2048 across eight columns, 2^25) reach both saturation limits at shift 0. Small operands at shift 2 land exactly on half-way points in both signs, which exposes the round half-up rule. The default sizes also leave room to chain two runs back to back while a fresh vector streams in.

// File: rtl/mvm_pkg.sv
package mvm_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} mvm_state_e;
endpackage

// File: rtl/mvm_coef_bank.sv
module mvm_coef_bank #(
  parameter int N      = 8,
  parameter int COEF_W = 12,
  localparam int IW    = $clog2(N)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [IW-1:0]         wr_row_i,
  input  logic [IW-1:0]         wr_col_i,
  input  logic [COEF_W-1:0]     wr_data_i,
  input  logic [IW-1:0]         rd_row_i,
  output logic [N*COEF_W-1:0]   rd_data_o
);
  logic [N-1:0][N-1:0][COEF_W-1:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mem_q <= '0;
    else if (we_i) mem_q[wr_row_i][wr_col_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_row_i];

  AST_COEF_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (mem_q[$past(wr_row_i)][$past(wr_col_i)] == $past(wr_data_i))); // R3
endmodule

// File: rtl/mvm_tap_reg.sv
module mvm_tap_reg #(
  parameter int N      = 8,
  parameter int DATA_W = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [DATA_W-1:0]   smp_i,
  input  logic                cap_i,
  output logic [N*DATA_W-1:0] vec_o
);
  logic [N-1:0][DATA_W-1:0] tap_q, vec_q;

  // newest sample enters at the top, oldest sits at column 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tap_q <= '0;
    else if (en_i) tap_q <= {smp_i, tap_q[N-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vec_q <= '0;
    else if (cap_i) vec_q <= tap_q;
  end

  assign vec_o = vec_q;

  AST_TAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(tap_q)); // R2
  AST_VEC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(vec_q)); // R9
endmodule

// File: rtl/mvm_adder_tree.sv
module mvm_adder_tree #(
  parameter int N     = 8,
  parameter int IN_W  = 24,
  localparam int LVLS = $clog2(N),
  localparam int OUT_W = IN_W + LVLS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [N*IN_W-1:0] leaf_i,
  output logic              vld_o,
  output logic [OUT_W-1:0]  sum_o
);
  logic [N-1:0][IN_W-1:0]    leaf;
  logic [2*N-2:0][OUT_W-1:0] tree;
  logic [N-2:0][OUT_W-1:0]   node_q;
  logic [LVLS-1:0]           vld_sr;

  assign leaf = leaf_i;

  // heap layout: internal nodes 0..N-2, leaves N-1..2N-2; one register per level
  always_comb begin
    for (int i = 0; i < N - 1; i++) tree[i] = node_q[i];
    for (int i = 0; i < N; i++)
      tree[N-1+i] = {{LVLS{leaf[i][IN_W-1]}}, leaf[i]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      node_q <= '0;
      vld_sr <= '0;
    end else begin
      for (int i = 0; i < N - 1; i++) node_q[i] <= tree[2*i+1] + tree[2*i+2];
      vld_sr[0] <= vld_i;
      for (int i = 1; i < LVLS; i++) vld_sr[i] <= vld_sr[i-1];
    end
  end

  assign sum_o = node_q[0];
  assign vld_o = vld_sr[LVLS-1];
endmodule

// File: rtl/mvm_rsl.sv
module mvm_rsl #(
  parameter int IN_W  = 27,
  parameter int OUT_W = 16,
  parameter int SH_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [IN_W-1:0]  sum_i,
  input  logic [SH_W-1:0]  shift_i,
  output logic             vld_o,
  output logic [OUT_W-1:0] res_o
);
  localparam logic signed [IN_W:0] MAXV = (IN_W+1)'(2**(OUT_W-1) - 1);
  localparam logic signed [IN_W:0] MINV = -MAXV - (IN_W+1)'(1);

  logic signed [IN_W:0] ext, rnd, shd;
  logic [OUT_W-1:0]     lim;

  always_comb begin
    ext = {sum_i[IN_W-1], sum_i};
    rnd = (shift_i == '0) ? '0 : ((IN_W+1)'(1) << (shift_i - SH_W'(1)));
    shd = (ext + rnd) >>> shift_i;
    if (shd > MAXV)      lim = MAXV[OUT_W-1:0];
    else if (shd < MINV) lim = MINV[OUT_W-1:0];
    else                 lim = shd[OUT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      res_o <= '0;
    end else begin
      vld_o <= vld_i;
      res_o <= vld_i ? lim : '0;
    end
  end

  AST_SAT_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && shift_i == '0 && ext > MAXV) |=> (res_o == MAXV[OUT_W-1:0])); // R10
  AST_SAT_NEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && shift_i == '0 && ext < MINV) |=> (res_o == MINV[OUT_W-1:0])); // R10
endmodule

// File: rtl/mvm_engine.sv
module mvm_engine #(
  parameter int N      = 8,
  parameter int DATA_W = 12,
  parameter int COEF_W = 12,
  parameter int OUT_W  = 16,
  localparam int IW    = $clog2(N),
  localparam int PW    = DATA_W + COEF_W,
  localparam int ACC_W = PW + $clog2(N),
  localparam int SH_W  = $clog2(ACC_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_en_i,
  input  logic [DATA_W-1:0] smp_i,
  input  logic              coef_we_i,
  input  logic [IW-1:0]     coef_row_i,
  input  logic [IW-1:0]     coef_col_i,
  input  logic [COEF_W-1:0] coef_i,
  input  logic              start_i,
  input  logic [SH_W-1:0]   shift_i,
  output logic [OUT_W-1:0]  res_o,
  output logic              res_vld_o
);
  import mvm_pkg::*;

  mvm_state_e             state_q;
  logic [IW-1:0]          row_q;
  logic                   run, last_row, accept;
  logic [N-1:0][COEF_W-1:0] coef_row;
  logic [N-1:0][DATA_W-1:0] vec;
  logic [N-1:0][PW-1:0]   prod_q;
  logic                   prod_vld_q;
  logic                   sum_vld;
  logic [ACC_W-1:0]       sum;

  assign run      = (state_q == ST_RUN);
  assign last_row = run && (row_q == IW'(N - 1));
  assign accept   = start_i && (!run || last_row);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
    end else if (accept) begin
      state_q <= ST_RUN;
      row_q   <= '0;
    end else if (run) begin
      row_q <= row_q + IW'(1);
      if (last_row) state_q <= ST_IDLE;
    end
  end

  mvm_coef_bank #(.N(N), .COEF_W(COEF_W)) u_bank (
    .clk_i, .rst_ni,
    .we_i      (coef_we_i),
    .wr_row_i  (coef_row_i),
    .wr_col_i  (coef_col_i),
    .wr_data_i (coef_i),
    .rd_row_i  (row_q),
    .rd_data_o (coef_row)
  );

  mvm_tap_reg #(.N(N), .DATA_W(DATA_W)) u_taps (
    .clk_i, .rst_ni,
    .en_i  (smp_en_i),
    .smp_i (smp_i),
    .cap_i (accept),
    .vec_o (vec)
  );

  for (genvar c = 0; c < N; c++) begin : g_mul
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prod_q[c] <= '0;
      else         prod_q[c] <= PW'($signed(coef_row[c])) * PW'($signed(vec[c]));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prod_vld_q <= 1'b0;
    else         prod_vld_q <= run;
  end

  mvm_adder_tree #(.N(N), .IN_W(PW)) u_tree (
    .clk_i, .rst_ni,
    .vld_i  (prod_vld_q),
    .leaf_i (prod_q),
    .vld_o  (sum_vld),
    .sum_o  (sum)
  );

  mvm_rsl #(.IN_W(ACC_W), .OUT_W(OUT_W), .SH_W(SH_W)) u_rsl (
    .clk_i, .rst_ni,
    .vld_i   (sum_vld),
    .sum_i   (sum),
    .shift_i (shift_i),
    .vld_o   (res_vld_o),
    .res_o   (res_o)
  );

  AST_ROW_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !last_row && !start_i) |=> (run && row_q == $past(row_q) + IW'(1))); // R5
  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !last_row && start_i) |=> (row_q != '0)); // R7
  AST_RUN_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_row && !start_i) |=> (state_q == ST_IDLE)); // R6
  AST_CHAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_row && start_i) |=> (run && row_q == '0)); // R8
endmodule

// File: tb/tb_mvm_engine.sv
`timescale 1ns/1ps
module tb_mvm_engine;
  localparam int N   = 8;
  localparam int DW  = 12;
  localparam int CW  = 12;
  localparam int OW  = 16;
  localparam int IW  = 3;
  localparam int SHW = 5;
  localparam int LAT = $clog2(N) + 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic smp_en_i = 1'b0;
  logic [DW-1:0] smp_i = '0;
  logic coef_we_i = 1'b0;
  logic [IW-1:0] coef_row_i = '0, coef_col_i = '0;
  logic [CW-1:0] coef_i = '0;
  logic start_i = 1'b0;
  logic [SHW-1:0] shift_i = '0;
  logic [OW-1:0] res_o;
  logic res_vld_o;

  mvm_engine dut (
    .clk_i, .rst_ni, .smp_en_i, .smp_i, .coef_we_i, .coef_row_i,
    .coef_col_i, .coef_i, .start_i, .shift_i, .res_o, .res_vld_o
  );

  always #4 clk_i = ~clk_i;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_acc = -1000;
  bit mon_on = 1'b0;
  string cur_req = "R1";
  int coef_m [N][N];
  int taps_m [N];
  int exp_val [int];

  always @(posedge clk_i) cyc++;

  function automatic int rsl(longint v, int s);
    longint t = v;
    if (s > 0) t = (t + (longint'(1) << (s - 1))) >>> s;
    if (t > 32767) t = 32767;
    if (t < -32768) t = -32768;
    return int'(t);
  endfunction

  function automatic int model_row(int r);
    longint s = 0;
    for (int c = 0; c < N; c++) s += longint'(coef_m[r][c]) * longint'(taps_m[c]);
    return rsl(s, int'(shift_i));
  endfunction

  // per-cycle comparison of valid and value against the schedule
  always @(negedge clk_i) begin
    if (mon_on) begin
      checks++;
      if (exp_val.exists(cyc)) begin
        if (!res_vld_o || $signed(res_o) != exp_val[cyc]) begin
          errors++;
          $display("FAIL %s cyc %0d vld %0b res %0d expected vld 1 res %0d",
                   cur_req, cyc, res_vld_o, $signed(res_o), exp_val[cyc]);
        end
      end else if (res_vld_o) begin
        errors++;
        $display("FAIL %s cyc %0d vld 1 res %0d expected vld 0", cur_req, cyc, $signed(res_o));
      end
    end
  end

  task automatic tick(bit en, int smp, bit st);
    int e;
    smp_en_i = en;
    smp_i = smp[DW-1:0];
    start_i = st;
    e = cyc + 1;
    if (st && e >= last_acc + N) begin
      last_acc = e;
      for (int r = 0; r < N; r++) exp_val[e + LAT + r] = model_row(r);
    end
    if (en) begin
      for (int i = 0; i < N - 1; i++) taps_m[i] = taps_m[i+1];
      taps_m[N-1] = smp;
    end
    @(negedge clk_i);
  endtask

  task automatic drain();
    for (int i = 0; i < LAT + N + 2; i++) tick(0, 0, 0);
  endtask

  task automatic load_matrix();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        coef_we_i = 1'b1;
        coef_row_i = IW'(r);
        coef_col_i = IW'(c);
        coef_i = coef_m[r][c][CW-1:0];
        @(negedge clk_i);
      end
    coef_we_i = 1'b0;
  endtask

  task automatic push_vec(int v []);
    foreach (v[i]) tick(1, v[i], 0);
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk_i);
    checks++;
    if (res_o !== '0 || res_vld_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 in reset res %0h vld %0b expected res 0 vld 0", res_o, res_vld_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    checks++;
    if (res_o !== '0 || res_vld_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 after reset res %0h vld %0b expected res 0 vld 0", res_o, res_vld_o);
    end
    mon_on = 1'b1;
  endtask

  // R2: identity matrix exposes the taps; disabled cycles carry junk samples
  task automatic t_ident();
    cur_req = "R2";
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) coef_m[r][c] = (r == c) ? 1 : 0;
    load_matrix();
    shift_i = '0;
    for (int i = 0; i < 12; i++) tick(i % 3 != 1, 100 * i - 500, 0);
    tick(0, 0, 1);
    drain();
  endtask

  // R3, R4: dense signed matrix and vector, windowed by shift 12
  task automatic t_matrix();
    cur_req = "R3/R4";
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) coef_m[r][c] = ((r * 37 + c * 11 + 5) * 97) % 4096 - 2048;
    load_matrix();
    shift_i = SHW'(12);
    for (int i = 0; i < N; i++) tick(1, ((i * 523 + 77) % 4096) - 2048, 0);
    tick(0, 0, 1);
    drain();
  endtask

  // R5: row ordering and latency with distinct per-row results
  task automatic t_order();
    cur_req = "R5";
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) coef_m[r][c] = (c == 0) ? r + 1 : 0;
    load_matrix();
    shift_i = '0;
    for (int i = 0; i < N; i++) tick(1, (i == 0) ? 7 : 0, 0);
    tick(0, 0, 1);
    drain();
  endtask

  // R6, R7: start during a busy run must add no results
  task automatic t_busy();
    cur_req = "R6/R7";
    tick(0, 0, 1);
    tick(0, 0, 0);
    tick(0, 0, 0);
    tick(0, 0, 1);
    tick(0, 0, 1);
    drain();
  endtask

  // R8, R9: new vector streams in during run one, chained start on last row
  task automatic t_chain();
    cur_req = "R8/R9";
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) coef_m[r][c] = (r - c) * 9 + 3;
    load_matrix();
    shift_i = '0;
    for (int i = 0; i < N; i++) tick(1, 40 * i - 150, 0);
    tick(1, 301, 1);
    for (int i = 1; i < N; i++) tick(1, 301 - 57 * i, 0);
    tick(0, 0, 1);
    drain();
  endtask

  // R10: saturation both ways at shift 0, then half-way rounding at shift 2
  task automatic t_rsl();
    cur_req = "R10";
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        coef_m[r][c] = (r == 0) ? -2048 : (r == 1) ? 2047 :
                       (r == 2 && c == 0) ? 3 : (r == 3 && c == 0) ? -1 : 0;
    load_matrix();
    shift_i = '0;
    for (int i = 0; i < N; i++) tick(1, -2048, 0);
    tick(0, 0, 1);
    drain();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) coef_m[r][c] = 0;
    coef_m[0][0] = 6;  coef_m[1][0] = -6; coef_m[2][0] = 5;
    coef_m[3][1] = 2;  coef_m[4][1] = 6;  coef_m[5][2] = 1;
    coef_m[6][2] = -1; coef_m[7][1] = -10;
    load_matrix();
    shift_i = SHW'(2);
    push_vec('{1, -1, 3, 0, 0, 0, 0, 0});
    tick(0, 0, 1);
    drain();
  endtask

  initial begin
    for (int i = 0; i < N; i++) taps_m[i] = 0;
    t_reset();
    t_ident();
    t_matrix();
    t_order();
    t_busy();
    t_chain();
    t_rsl();
    mon_on = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule